// File: doc/BRIEF.md
# System Call Trap State Unit

This block works out the processor state that follows a system call. When the execute stage raises the take strobe, the unit samples four values: the address of the trapping instruction, the current 64-bit machine state word, the level field of the instruction and the secure-mode control enable. One clock later it presents four results together. These are the return address to save, the filtered copy of the old machine state, the machine state that the handler runs with, and the fixed handler entry address. A done pulse of one cycle marks the update.

A small control part decodes the level field and the secure enable into a few strobes. A datapath part holds the four result registers. The old state is saved only in three fixed bit ranges. The new state keeps the machine-check enable bit and clears every other bit. The exceptions are the hypervisor bit and the secure bit, whose handling depends on the level value. All bit positions use LSB-0 numbering.

Top module: `syscall_state_unit`

## Requirements
- R1: One cycle after a strobe, saveAddr equals the sampled curAddr plus 4, wrapping modulo 2^64.
- R2: One cycle after a strobe, saveMsr holds curMsr bits 0..32, 37..41 and 48..63 unchanged, and all its other bits are zero.
- R3: One cycle after a strobe, nextAddr equals 0x0000_0000_0000_0C00.
- R4: One cycle after a strobe, bit 12 (machine-check enable) of newMsr equals that bit of curMsr. Every newMsr bit other than 12, 22 and 60 is zero; this covers the relocation, floating-point mode, external interrupt and recoverable bits.
- R5: For any level value other than 1 and 2 (0 included), newMsr bit 60 (hypervisor) and bit 22 (secure) equal the sampled curMsr bits.
- R6: For level 1, newMsr bit 60 is 1 and bit 22 equals the sampled curMsr bit.
- R7: For level 2, newMsr bit 22 is 1 when secureCtlEn is 1 and otherwise equals the sampled bit. Bit 60 equals the sampled bit.
- R8: done is 1 in exactly the cycle after each cycle in which the strobe was high, and 0 otherwise.
- R9: While the strobe is low, all four result outputs keep their values, whatever the other inputs do.
- R10: When rstN is low at a clock edge, all outputs are zero after that edge, even if the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| takeSc | input | 1 | Take-system-call strobe |
| curAddr | input | 64 | Address of the trapping instruction |
| curMsr | input | 64 | Current machine state word |
| levField | input | 7 | Level field of the instruction |
| secureCtlEn | input | 1 | Secure-mode control enable |
| saveAddr | output | 64 | Return address to save |
| saveMsr | output | 64 | Filtered copy of the old machine state |
| newMsr | output | 64 | Machine state for the handler |
| nextAddr | output | 64 | Handler entry address |
| done | output | 1 | One-cycle update pulse |

## Verification
The hardest cases to reach from the ports are the level values that must fall back to the level-0 rule, and strobes held high for several cycles in a row. In those cases done must stay high and the results must follow the latest sample. The stimulus sweeps a single set bit across all 64 machine-state positions, and also the all-ones and all-zero words. Each sweep runs for levels 0, 1, 2, 3 and 127, with the secure enable both off and on. After the sweeps come a run of back-to-back strobes, a return address that wraps, and a reset asserted while the strobe is high.

// File: rtl/sysc_pkg.sv
`timescale 1ns/1ps
package sysc_pkg;
  localparam int ADDR_W = 64;
  localparam int MSR_W  = 64;
  localparam int LEV_W  = 7;

  // retained positions in the handler state word
  localparam int ME_POS = 12;
  localparam int S_POS  = 22;
  localparam int HV_POS = 60;

  // saved ranges of the old state word (inclusive, LSB-0)
  localparam int KEEP_A_LO = 0;
  localparam int KEEP_A_HI = 32;
  localparam int KEEP_B_LO = 37;
  localparam int KEEP_B_HI = 41;
  localparam int KEEP_C_LO = 48;
  localparam int KEEP_C_HI = 63;

  localparam logic [ADDR_W-1:0] TRAP_VECTOR = ADDR_W'(64'h0000_0000_0000_0C00);

  typedef struct packed {
    logic load;
    logic hvSet;
    logic sSet;
  } scStrobe_t;

  function automatic logic inSaveRange(input int b);
    return (b >= KEEP_A_LO && b <= KEEP_A_HI) ||
           (b >= KEEP_B_LO && b <= KEEP_B_HI) ||
           (b >= KEEP_C_LO && b <= KEEP_C_HI);
  endfunction
endpackage

// File: rtl/sysc_ctrl.sv
`timescale 1ns/1ps
module sysc_ctrl
  import sysc_pkg::*;
#(
  parameter int LW = LEV_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          takeSc,
  input  logic [LW-1:0] levField,
  input  logic          secureCtlEn,
  output scStrobe_t     strobes,
  output logic          done
);
  localparam logic [LW-1:0] LEV_HV  = LW'(1);
  localparam logic [LW-1:0] LEV_SEC = LW'(2);

  logic doneQ;

  always_comb begin
    strobes.load  = takeSc;
    strobes.hvSet = (levField == LEV_HV);
    strobes.sSet  = (levField == LEV_SEC) && secureCtlEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= takeSc;
  end

  assign done = doneQ;
endmodule

// File: rtl/sysc_datapath.sv
`timescale 1ns/1ps
module sysc_datapath
  import sysc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int MW = MSR_W,
  parameter logic [AW-1:0] VECTOR = TRAP_VECTOR
) (
  input  logic          clk,
  input  logic          rstN,
  input  scStrobe_t     strobes,
  input  logic [AW-1:0] curAddr,
  input  logic [MW-1:0] curMsr,
  output logic [AW-1:0] saveAddr,
  output logic [MW-1:0] saveMsr,
  output logic [MW-1:0] newMsr,
  output logic [AW-1:0] nextAddr
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic [MW-1:0] keepMask;
  logic [MW-1:0] msrNext;
  logic [AW-1:0] saveAddrQ, nextAddrQ;
  logic [MW-1:0] saveMsrQ, newMsrQ;

  for (genvar b = 0; b < MW; b++) begin : g_mask
    assign keepMask[b] = inSaveRange(b);
  end

  always_comb begin
    msrNext         = '0;
    msrNext[ME_POS] = curMsr[ME_POS];
    msrNext[HV_POS] = curMsr[HV_POS] | strobes.hvSet;
    msrNext[S_POS]  = curMsr[S_POS] | strobes.sSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      saveAddrQ <= '0;
      saveMsrQ  <= '0;
      newMsrQ   <= '0;
      nextAddrQ <= '0;
    end else if (strobes.load) begin
      saveAddrQ <= curAddr + INSN_BYTES;
      saveMsrQ  <= curMsr & keepMask;
      newMsrQ   <= msrNext;
      nextAddrQ <= VECTOR;
    end
  end

  assign saveAddr = saveAddrQ;
  assign saveMsr  = saveMsrQ;
  assign newMsr   = newMsrQ;
  assign nextAddr = nextAddrQ;
endmodule

// File: rtl/syscall_state_unit.sv
`timescale 1ns/1ps
module syscall_state_unit
  import sysc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              takeSc,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [MSR_W-1:0]  curMsr,
  input  logic [LEV_W-1:0]  levField,
  input  logic              secureCtlEn,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [MSR_W-1:0]  saveMsr,
  output logic [MSR_W-1:0]  newMsr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              done
);
  scStrobe_t strobes;

  sysc_ctrl #(.LW(LEV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .takeSc(takeSc), .levField(levField),
    .secureCtlEn(secureCtlEn), .strobes(strobes), .done(done)
  );

  sysc_datapath #(.AW(ADDR_W), .MW(MSR_W), .VECTOR(TRAP_VECTOR)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curAddr(curAddr),
    .curMsr(curMsr), .saveAddr(saveAddr), .saveMsr(saveMsr),
    .newMsr(newMsr), .nextAddr(nextAddr)
  );
endmodule

// File: rtl/sysc_checker.sv
`timescale 1ns/1ps
module sysc_checker
  import sysc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              takeSc,
  input logic [ADDR_W-1:0] curAddr,
  input logic [MSR_W-1:0]  curMsr,
  input logic [LEV_W-1:0]  levField,
  input logic              secureCtlEn,
  input logic [ADDR_W-1:0] saveAddr,
  input logic [MSR_W-1:0]  saveMsr,
  input logic [MSR_W-1:0]  newMsr,
  input logic [ADDR_W-1:0] nextAddr,
  input logic              done
);
  localparam logic [MSR_W-1:0] SAVE_MASK =
    (MSR_W'(64'h1_FFFF_FFFF)) | (MSR_W'(64'h1F) << 37) | (MSR_W'(64'hFFFF) << 48);
  localparam logic [MSR_W-1:0] LIVE_BITS =
    (MSR_W'(1) << ME_POS) | (MSR_W'(1) << S_POS) | (MSR_W'(1) << HV_POS);

  p_ret_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    takeSc |=> saveAddr == $past(curAddr) + ADDR_W'(4));

  p_save_msr_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeSc |=> saveMsr == ($past(curMsr) & SAVE_MASK));

  p_vector_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeSc |=> nextAddr == ADDR_W'(64'hC00));

  p_me_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeSc |=> newMsr[ME_POS] == $past(curMsr[ME_POS]));

  p_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeSc |=> (newMsr & ~LIVE_BITS) == '0);

  p_lev0_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeSc && levField != LEV_W'(1) && levField != LEV_W'(2)
      |=> newMsr[HV_POS] == $past(curMsr[HV_POS]) && newMsr[S_POS] == $past(curMsr[S_POS]));

  p_lev1_r6: assert property (@(posedge clk) disable iff (!rstN)
    takeSc && levField == LEV_W'(1)
      |=> newMsr[HV_POS] && newMsr[S_POS] == $past(curMsr[S_POS]));

  p_lev2_r7: assert property (@(posedge clk) disable iff (!rstN)
    takeSc && levField == LEV_W'(2)
      |=> newMsr[S_POS] == ($past(secureCtlEn) | $past(curMsr[S_POS]))
          && newMsr[HV_POS] == $past(curMsr[HV_POS]));

  p_done_hi_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeSc |=> done);

  p_done_lo_r8: assert property (@(posedge clk) disable iff (!rstN)
    !takeSc |=> !done);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !takeSc |=> $stable(saveAddr) && $stable(saveMsr) && $stable(newMsr) && $stable(nextAddr));
endmodule

bind syscall_state_unit sysc_checker uChk (
  .clk(clk), .rstN(rstN), .takeSc(takeSc), .curAddr(curAddr), .curMsr(curMsr),
  .levField(levField), .secureCtlEn(secureCtlEn), .saveAddr(saveAddr),
  .saveMsr(saveMsr), .newMsr(newMsr), .nextAddr(nextAddr), .done(done)
);

// File: tb/sim_syscall_state_unit.sv
`timescale 1ns/1ps
module sim_syscall_state_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        takeSc = 1'b0;
  logic [63:0] curAddr = '0;
  logic [63:0] curMsr = '0;
  logic [6:0]  levField = '0;
  logic        secureCtlEn = 1'b0;
  logic [63:0] saveAddr, saveMsr, newMsr, nextAddr;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  localparam logic [63:0] SAVE_MASK = 64'h1_FFFF_FFFF | (64'h1F << 37) | (64'hFFFF << 48);

  always #10 clk = ~clk;   // 50 MHz

  syscall_state_unit u0 (
    .clk(clk), .rstN(rstN), .takeSc(takeSc), .curAddr(curAddr), .curMsr(curMsr),
    .levField(levField), .secureCtlEn(secureCtlEn), .saveAddr(saveAddr),
    .saveMsr(saveMsr), .newMsr(newMsr), .nextAddr(nextAddr), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] expNewMsr(input logic [63:0] m, input int lev, input bit smf);
    logic hv, s;
    hv = m[60];
    s  = m[22];
    if (lev == 1) hv = 1'b1;
    if (lev == 2 && smf) s = 1'b1;
    return (64'(m[12]) << 12) | (64'(hv) << 60) | (64'(s) << 22);
  endfunction

  // drives one strobe cycle and checks the results after the capturing edge
  task automatic doCall(input logic [63:0] a, input logic [63:0] m, input int lev, input bit smf);
    logic [63:0] expN;
    @(negedge clk);
    curAddr = a; curMsr = m; levField = 7'(lev); secureCtlEn = smf; takeSc = 1'b1;
    @(negedge clk);
    takeSc = 1'b0;
    expN = expNewMsr(m, lev, smf);
    chk("R1 saveAddr", saveAddr, a + 64'd4);
    chk("R2 saveMsr", saveMsr, m & SAVE_MASK);
    chk("R3 nextAddr", nextAddr, 64'hC00);
    chk("R4 newMsr ME/cleared", newMsr & ~((64'd1 << 22) | (64'd1 << 60)), expN & (64'd1 << 12));
    if (lev == 1)      chk("R6 newMsr lev1", newMsr, expN);
    else if (lev == 2) chk("R7 newMsr lev2", newMsr, expN);
    else               chk("R5 newMsr lev0-like", newMsr, expN);
    chk("R8 done after strobe", 64'(done), 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] hA, hS, hN, hV;
    int levs[5] = '{0, 1, 2, 3, 127};
    // R10: reset held with strobe high and busy inputs
    curAddr = 64'hDEAD_BEEF_0000_1000; curMsr = '1; levField = 7'd2; secureCtlEn = 1'b1; takeSc = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 saveAddr reset", saveAddr, '0);
    chk("R10 saveMsr reset", saveMsr, '0);
    chk("R10 newMsr reset", newMsr, '0);
    chk("R10 nextAddr reset", nextAddr, '0);
    chk("R10 done reset", 64'(done), 64'd0);
    takeSc = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 done idle", 64'(done), 64'd0);

    // sweep single-bit, all-ones and zero state words across levels and enable
    for (int li = 0; li < 5; li++) begin
      for (int e = 0; e < 2; e++) begin
        for (int b = 0; b < 66; b++) begin
          logic [63:0] m;
          m = (b < 64) ? (64'd1 << b) : ((b == 64) ? '1 : '0);
          doCall(64'h1000 + 64'(b * 8), m, levs[li], bit'(e));
        end
      end
    end

    // R1: wrap of the return address
    doCall(64'hFFFF_FFFF_FFFF_FFFC, 64'h0123_4567_89AB_CDEF, 0, 1'b0);
    chk("R1 wrap", saveAddr, 64'd0);

    // R9: strobe low, inputs changing, outputs hold and done stays low
    hA = saveAddr; hS = saveMsr; hN = newMsr; hV = nextAddr;
    for (int k = 0; k < 4; k++) begin
      curAddr = 64'(k) * 64'h1111; curMsr = ~curMsr; levField = 7'(k); secureCtlEn = ~secureCtlEn;
      @(negedge clk);
      chk("R9 hold saveAddr", saveAddr, hA);
      chk("R9 hold saveMsr", saveMsr, hS);
      chk("R9 hold newMsr", newMsr, hN);
      chk("R9 hold nextAddr", nextAddr, hV);
      chk("R8 done low", 64'(done), 64'd0);
    end

    // back-to-back strobes: done stays high, latest sample wins
    takeSc = 1'b1;
    for (int k = 0; k < 3; k++) begin
      curAddr = 64'h8000 + 64'(k * 4); curMsr = (k == 1) ? '1 : 64'(k); levField = 7'(k); secureCtlEn = 1'b1;
      @(negedge clk);
      chk("R8 done back-to-back", 64'(done), 64'd1);
      chk("R1 back-to-back", saveAddr, 64'h8004 + 64'(k * 4));
      chk("R5 R6 R7 back-to-back", newMsr, expNewMsr(curMsr, k, 1'b1));
    end
    takeSc = 1'b0;
    @(negedge clk);
    chk("R8 done falls", 64'(done), 64'd0);

    // R10: reset mid-run with strobe high clears everything
    doCall(64'h4444, '1, 1, 1'b0);
    rstN = 1'b0; takeSc = 1'b1;
    @(negedge clk);
    chk("R10 mid saveAddr", saveAddr, '0);
    chk("R10 mid saveMsr", saveMsr, '0);
    chk("R10 mid newMsr", newMsr, '0);
    chk("R10 mid nextAddr", nextAddr, '0);
    chk("R10 mid done", 64'(done), 64'd0);
    takeSc = 1'b0; rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule